// File: doc/BRIEF.md
# System Bus Address Decoder with Boot Remap

This block sits in front of the slaves of a 32-bit system bus. It decodes the address of every valid transfer and raises exactly one select for the slave that owns the address. When no slave owns the address, it raises an abort flag instead. The decoder is purely combinational except for one sticky remap flag.

The first decode level splits the address space into sixteen 256 MB banks using the top four address bits. Six banks drive external chip selects and one bank drives the peripheral bridge. The rest abort. Bank 0 is split again into 1 MB regions for the on-chip ROM and SRAM. Region 0 is an alias, and the slave behind it changes with boot mode and remap. Before remap, a high boot-mode input puts the ROM at address zero and a low input puts external chip select 0 there. A one-cycle remap command permanently moves the SRAM to address zero until the next reset.

The offset output carries the address as seen by the selected slave. For the external banks and the peripheral bridge it is the 28-bit in-bank offset. For the bank 0 regions it is the 20-bit in-region offset.

Top module: `bus_addr_decoder`

## Requirements
- R1: A valid access to bank 1..6 (addr[31:28]) raises selExt[bank-1] only, with slaveOffset = addr[27:0].
- R2: A valid access to bank 15 raises selPeriph only, with slaveOffset = addr[27:0].
- R3: A valid access to banks 7..14 raises abortFlag only, and slaveOffset is 0.
- R4: In bank 0, region 1 (addr[27:20] = 1) always raises selRom, with slaveOffset = addr[19:0].
- R5: In bank 0, region 3 raises selSram with slaveOffset = addr[19:0] when addr[19:0] < 32768, and raises abortFlag otherwise.
- R6: Before remap, with bootSel high, region 0 of bank 0 raises selRom with slaveOffset = addr[19:0].
- R7: Before remap, with bootSel low, region 0 of bank 0 raises selExt[0] with slaveOffset = addr[19:0].
- R8: A remapCmd high at a clock edge sets the remap state from that edge on. After that, region 0 behaves as the SRAM region of R5, whatever bootSel is.
- R9: The remap state stays set until reset, and reset clears it.
- R10: Any other region of bank 0 (regions 2 and 4..255) raises abortFlag.
- R11: With xferValid low, all selects and abortFlag are low and slaveOffset is 0.
- R12: With xferValid high, exactly one of the nine selects and abortFlag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the remap state |
| rstN | input | 1 | Active-low asynchronous reset |
| xferValid | input | 1 | Transfer valid strobe |
| busAddr | input | 32 | Transfer byte address |
| bootSel | input | 1 | Boot mode: 1 = ROM at zero, 0 = external select 0 at zero |
| remapCmd | input | 1 | One-cycle command that moves the SRAM to address zero |
| selRom | output | 1 | Internal ROM select |
| selSram | output | 1 | Internal SRAM select |
| selExt | output | 6 | External chip selects, bit i for bank i+1 |
| selPeriph | output | 1 | Peripheral bridge select |
| abortFlag | output | 1 | Access to unmapped space |
| slaveOffset | output | 28 | Offset passed to the selected slave |

## Verification
Each of the sixteen banks is exercised, so that an error in the bank-to-select mapping shows up. Bank 0 is probed at its alias, ROM, SRAM and unused regions, including the SRAM limit addresses 0x7FFF and 0x8000, to catch wrong region numbers and off-by-one size checks. Region 0 is tried under both boot modes, before and after a remap pulse, and again after a second reset. This separates a missing, non-sticky or non-clearing remap flag from a boot-mode decode error. Accesses with the valid strobe low, at mapped addresses, confirm that nothing is selected.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;
  // Strobes from the remap control to the decode datapath
  typedef struct packed {
    logic remapped;   // SRAM owns region 0
    logic zeroToRom;  // ROM owns region 0
    logic zeroToExt;  // external select 0 owns region 0
  } zeroMapT;
endpackage

// File: rtl/addr_remap_ctrl.sv
module addr_remap_ctrl
  import addr_dec_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    bootSel,
  input  logic    remapCmd,
  output zeroMapT zeroMap
);
  logic remapFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         remapFlag <= 1'b0;
    else if (remapCmd) remapFlag <= 1'b1;
  end

  always_comb begin
    zeroMap.remapped  = remapFlag;
    zeroMap.zeroToRom = !remapFlag && bootSel;
    zeroMap.zeroToExt = !remapFlag && !bootSel;
  end

  // R8
  remap_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    remapCmd |=> remapFlag);
  // R9
  remap_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    remapFlag |=> remapFlag);
endmodule

// File: rtl/addr_decode_dp.sv
module addr_decode_dp
  import addr_dec_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BANK_BITS   = 4,
  parameter int REGION_W    = 20,
  parameter int NUM_EXT     = 6,
  parameter int EXT_FIRST   = 1,
  parameter int PERIPH_BANK = 15,
  parameter int ROM_REGION  = 1,
  parameter int SRAM_REGION = 3,
  parameter int SRAM_BYTES  = 32768
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               xferValid,
  input  logic [ADDR_W-1:0]  busAddr,
  input  zeroMapT            zeroMap,
  output logic               selRom,
  output logic               selSram,
  output logic [NUM_EXT-1:0] selExt,
  output logic               selPeriph,
  output logic               abortFlag,
  output logic [ADDR_W-BANK_BITS-1:0] slaveOffset
);
  localparam int OFF_W  = ADDR_W - BANK_BITS;
  localparam int REG_IW = OFF_W - REGION_W;

  logic [BANK_BITS-1:0] bank;
  logic [REG_IW-1:0]    region;
  logic [REGION_W-1:0]  regionOff;
  logic [NUM_EXT-1:0]   extBankHit;
  logic                 inBank0, isZero, sramFits, anyExtBank;

  assign bank      = busAddr[ADDR_W-1 -: BANK_BITS];
  assign region    = busAddr[OFF_W-1 -: REG_IW];
  assign regionOff = busAddr[REGION_W-1:0];
  assign inBank0   = (bank == '0);
  assign isZero    = (region == '0);
  assign sramFits  = ({{(32-REGION_W){1'b0}}, regionOff} < 32'(SRAM_BYTES));

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_extBank
    assign extBankHit[i] = (bank == BANK_BITS'(EXT_FIRST + i));
  end
  assign anyExtBank = |extBankHit;

  always_comb begin
    selRom      = 1'b0;
    selSram     = 1'b0;
    selExt      = '0;
    selPeriph   = 1'b0;
    abortFlag   = 1'b0;
    slaveOffset = '0;
    if (xferValid) begin
      if (inBank0) begin
        if (region == REG_IW'(ROM_REGION) || (isZero && zeroMap.zeroToRom)) begin
          selRom      = 1'b1;
          slaveOffset = OFF_W'(regionOff);
        end else if (region == REG_IW'(SRAM_REGION) || (isZero && zeroMap.remapped)) begin
          if (sramFits) begin
            selSram     = 1'b1;
            slaveOffset = OFF_W'(regionOff);
          end else begin
            abortFlag = 1'b1;
          end
        end else if (isZero && zeroMap.zeroToExt) begin
          selExt[0]   = 1'b1;
          slaveOffset = OFF_W'(regionOff);
        end else begin
          abortFlag = 1'b1;
        end
      end else if (anyExtBank) begin
        selExt      = extBankHit;
        slaveOffset = busAddr[OFF_W-1:0];
      end else if (bank == BANK_BITS'(PERIPH_BANK)) begin
        selPeriph   = 1'b1;
        slaveOffset = busAddr[OFF_W-1:0];
      end else begin
        abortFlag = 1'b1;
      end
    end
  end

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !xferValid |-> ({selRom, selSram, selExt, selPeriph, abortFlag} == '0 && slaveOffset == '0));
  // R12
  one_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferValid |-> $countones({selRom, selSram, selExt, selPeriph, abortFlag}) == 1);
  // R2
  periph_bank_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xferValid && bank == BANK_BITS'(PERIPH_BANK)) |-> selPeriph);
  // R8
  zero_after_remap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xferValid && inBank0 && isZero && zeroMap.remapped) |-> !selRom && !selExt[0]);
endmodule

// File: rtl/bus_addr_decoder.sv
module bus_addr_decoder
  import addr_dec_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BANK_BITS = 4,
  parameter int NUM_EXT   = 6
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               xferValid,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               bootSel,
  input  logic               remapCmd,
  output logic               selRom,
  output logic               selSram,
  output logic [NUM_EXT-1:0] selExt,
  output logic               selPeriph,
  output logic               abortFlag,
  output logic [ADDR_W-BANK_BITS-1:0] slaveOffset
);
  zeroMapT zeroMap;

  addr_remap_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .bootSel(bootSel), .remapCmd(remapCmd), .zeroMap(zeroMap)
  );

  addr_decode_dp #(.ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS), .NUM_EXT(NUM_EXT)) u_dp (
    .clk(clk), .rstN(rstN), .xferValid(xferValid), .busAddr(busAddr), .zeroMap(zeroMap),
    .selRom(selRom), .selSram(selSram), .selExt(selExt), .selPeriph(selPeriph),
    .abortFlag(abortFlag), .slaveOffset(slaveOffset)
  );
endmodule

// File: tb/tb_bus_addr_decoder.sv
module tb_bus_addr_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        xferValid = 1'b0;
  logic [31:0] busAddr = '0;
  logic        bootSel = 1'b0;
  logic        remapCmd = 1'b0;
  logic        selRom, selSram, selPeriph, abortFlag;
  logic [5:0]  selExt;
  logic [27:0] slaveOffset;

  int checks = 0;
  int errors = 0;
  bit modelRemap = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bus_addr_decoder dut (
    .clk(clk), .rstN(rstN), .xferValid(xferValid), .busAddr(busAddr), .bootSel(bootSel),
    .remapCmd(remapCmd), .selRom(selRom), .selSram(selSram), .selExt(selExt),
    .selPeriph(selPeriph), .abortFlag(abortFlag), .slaveOffset(slaveOffset)
  );

  // Behavioural reference: bit 9 rom, 8 sram, 7:2 ext[5:0], 1 periph, 0 abort
  function automatic void refModel(input bit v, input logic [31:0] a, input bit b, input bit rm,
                                   output logic [9:0] s, output logic [27:0] o);
    int bank = int'(a[31:28]);
    int rgn  = int'(a[27:20]);
    int lo   = int'(a[19:0]);
    s = '0; o = '0;
    if (!v) return;
    if (bank == 0) begin
      if (rgn == 1 || (rgn == 0 && !rm && b)) begin s[9] = 1; o = 28'(lo); end
      else if (rgn == 3 || (rgn == 0 && rm)) begin
        if (lo < 32768) begin s[8] = 1; o = 28'(lo); end else s[0] = 1;
      end
      else if (rgn == 0) begin s[2] = 1; o = 28'(lo); end
      else s[0] = 1;
    end else if (bank >= 1 && bank <= 6) begin
      s[bank + 1] = 1; o = a[27:0];
    end else if (bank == 15) begin
      s[1] = 1; o = a[27:0];
    end else s[0] = 1;
  endfunction

  task automatic step(input bit v, input logic [31:0] a, input bit b, input bit rc, input string req);
    logic [9:0]  expS;
    logic [27:0] expO;
    logic [9:0]  actS;
    @(negedge clk);
    xferValid = v; busAddr = a; bootSel = b; remapCmd = rc;
    #2;
    refModel(v, a, b, modelRemap, expS, expO);
    actS = {selRom, selSram, selExt, selPeriph, abortFlag};
    checks++;
    if (actS !== expS || slaveOffset !== expO) begin
      errors++;
      $display("FAIL %s addr=%h sel=%b off=%h expected sel=%b off=%h", req, a, actS, slaveOffset, expS, expO);
    end
    @(posedge clk);
    if (rc && rstN) modelRemap = 1'b1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; xferValid = 0; remapCmd = 0;
    modelRemap = 1'b0;
    #2;
    checks++;
    if ({selRom, selSram, selExt, selPeriph, abortFlag} !== '0 || slaveOffset !== '0) begin
      errors++;
      $display("FAIL R11 reset outputs=%b expected 0", {selRom, selSram, selExt, selPeriph, abortFlag});
    end
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1, R2, R3: every bank, boot high
    for (int bk = 1; bk < 16; bk++)
      step(1, {4'(bk), 28'h0ABC123}, 1, 0, "R1/R2/R3 bank sweep");
    step(1, 32'h1000_0000, 1, 0, "R1");
    step(1, 32'h6FFF_FFFF, 1, 0, "R1");
    step(1, 32'hF000_0004, 0, 0, "R2");
    step(1, 32'h7000_0000, 0, 0, "R3");
    step(1, 32'hEFFF_FFFF, 0, 0, "R3");
    // R4
    step(1, 32'h0010_0000, 1, 0, "R4");
    step(1, 32'h001F_FFFC, 0, 0, "R4");
    // R5
    step(1, 32'h0030_0000, 1, 0, "R5");
    step(1, 32'h0030_7FFF, 1, 0, "R5");
    step(1, 32'h0030_8000, 1, 0, "R5 limit");
    // R10
    step(1, 32'h0020_0010, 1, 0, "R10");
    step(1, 32'h0040_0000, 1, 0, "R10");
    step(1, 32'h0FF0_0000, 0, 0, "R10");
    // R6, R7
    step(1, 32'h0000_1234, 1, 0, "R6");
    step(1, 32'h0000_9234, 1, 0, "R6");
    step(1, 32'h0000_1234, 0, 0, "R7");
    step(1, 32'h000F_FFFF, 0, 0, "R7");
    // R11
    step(0, 32'h0010_0000, 1, 0, "R11");
    step(0, 32'hF000_0000, 1, 0, "R11");
    step(0, 32'h9000_0000, 0, 0, "R11");
    // R8: remap pulse with valid low, then region 0 is SRAM
    step(0, 32'h0, 0, 1, "R8 pulse");
    step(1, 32'h0000_0100, 0, 0, "R8");
    step(1, 32'h0000_0100, 1, 0, "R8");
    step(1, 32'h0000_7FFF, 1, 0, "R8");
    step(1, 32'h0000_8000, 0, 0, "R8 limit");
    step(1, 32'h0010_0040, 1, 0, "R4 after remap");
    step(1, 32'h1000_0040, 1, 0, "R1 after remap");
    // R9: sticky over many cycles and a second pulse
    for (int k = 0; k < 5; k++) step(0, 32'h0, k[0], 0, "R9 idle");
    step(1, 32'h0000_0020, 1, 1, "R9");
    step(1, 32'h0000_0020, 0, 0, "R9");
    // R9: reset clears remap
    doReset();
    step(1, 32'h0000_0020, 1, 0, "R9 cleared R6");
    step(1, 32'h0000_0020, 0, 0, "R9 cleared R7");
    // R12 with mixed traffic
    step(1, 32'h5123_4567, 0, 0, "R12");
    step(1, 32'hB000_0000, 1, 0, "R12");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule